// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the write engine of a 1M x 8 flash memory. It watches host write cycles, turns one- and two-cycle opcode sequences into read-mode changes, status clears and operation requests, and chooses what a host read returns: array bytes, identifier codes or a status byte. Write cycles are sampled synchronously. The rising edge of the active-low write strobe is detected in the clock domain, and the address and data present at that edge are captured. No addressable location is used by the command register.

Erase and byte-write sequences that complete correctly produce a request to a separate write state machine on a valid/ready channel. The request carries the operation kind, the target address and, for a byte write, the data. The request holds `req_valid` and all payload fields stable until the engine asserts `req_ready`, and the transfer happens in the cycle where both are high. There is no back-pressure towards the host bus. While a request is waiting or the engine is working, new host commands are filtered instead. The engine reports the end of its work with a one-cycle `wsm_done` pulse. An erase can be held by the host, and the `erase_hold` level tells the engine to pause.

Top module: `flash_cmd_if`

## Requirements
- R1: A host write is taken only when `we_n` goes from 0 to 1 while `ce_n` is 0. The address and data present at that edge are used. A strobe with `ce_n` high has no effect.
- R2: After reset, reads return `array_rdata`. Opcode FFh also selects array reads.
- R3: Opcode 90h selects identifier reads. Address 0 returns parameter MAKER_ID, address 1 returns DEVICE_ID, and any other address returns 00h.
- R4: Opcode 70h selects status reads. The status byte is {bit7 ready, bit6 erase held, bit5 erase error, bit4 write error, bit3 voltage low, bits2..0 zero}.
- R5: Bits 5, 4 and 3 are sticky. Opcode 50h clears all three in one write cycle and leaves the read mode as it was.
- R6: The sequence 20h then D0h, with `vpp_ok` high, raises a request with `req_kind`=0. Its address is the confirm cycle's address with the low 16 bits forced to zero.
- R7: Opcode 40h or 10h, followed by any byte, with `vpp_ok` high, raises a request with `req_kind`=1. The request carries the second cycle's address and data.
- R8: A raised request keeps `req_valid`, `req_kind`, `req_addr` and `req_data` unchanged until a cycle with `req_ready` high, then drops `req_valid`.
- R9: If `vpp_ok` is low when an erase or write sequence completes, no request is raised. Bit 3 is set, together with bit 5 for an erase or bit 4 for a write.
- R10: An erase setup followed by any byte other than D0h raises no request and sets bits 5 and 4.
- R11: From a request until `wsm_done`, only 70h and B0h are honoured, and B0h only during an erase. B0h sets bit 6 and `erase_hold`. While the erase is held, FFh, 90h and 70h are honoured, and D0h clears the hold.
- R12: Completing an erase or write sequence, including a rejected one, switches reads to status. Undefined opcodes change nothing, including the read mode.
- R13: Status bit 7 is 0 from the request until `wsm_done`, except while the erase is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 20 | Host byte address |
| din | input | 8 | Host write data |
| vpp_ok | input | 1 | Programming voltage is valid |
| array_rdata | input | 8 | Byte read from the array at `addr` |
| host_rdata | output | 8 | Byte returned to a host read |
| req_valid | output | 1 | Operation request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_kind | output | 1 | 0 erase, 1 byte write |
| req_addr | output | 20 | Block base or byte address |
| req_data | output | 8 | Byte to program |
| wsm_done | input | 1 | One-cycle pulse, operation finished |
| erase_hold | output | 1 | Pause the running erase |

## Verification
Assertions check the following on every cycle:
- write capture only on a qualified strobe edge;
- request payload stability under back-pressure;
- the voltage gate on request launch;
- block alignment of erase addresses;
- that the error bits fall only on a clear command;
- that a hold exists only during a running erase.

Some behaviours can only be shown by the bench's scenarios:
- the full opcode decode, swept across every byte value;
- the filtering of commands while busy or held;
- the switch to status reads;
- the exact status bytes after the error sequences.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_IDENT = 2'd1, RD_STATUS = 2'd2} rd_mode_e;
  typedef enum logic [1:0] {SEQ_IDLE = 2'd0, SEQ_ERASE = 2'd1, SEQ_WRITE = 2'd2} seq_e;

  localparam logic REQ_ERASE = 1'b0;
  localparam logic REQ_WRITE = 1'b1;

  localparam logic [7:0] OPC_ARRAY   = 8'hFF;
  localparam logic [7:0] OPC_IDENT   = 8'h90;
  localparam logic [7:0] OPC_STATUS  = 8'h70;
  localparam logic [7:0] OPC_CLEAR   = 8'h50;
  localparam logic [7:0] OPC_ERASE   = 8'h20;
  localparam logic [7:0] OPC_CONFIRM = 8'hD0;
  localparam logic [7:0] OPC_HOLD    = 8'hB0;
  localparam logic [7:0] OPC_WRITE_A = 8'h40;
  localparam logic [7:0] OPC_WRITE_B = 8'h10;
endpackage

// File: rtl/fci_bus_capture.sv
module fci_bus_capture #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          cap_valid,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);
  logic we_q;
  logic strobe_rise;

  assign strobe_rise = we_n & ~we_q & ~ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      we_q      <= we_n;
      cap_valid <= strobe_rise;
      if (strobe_rise) begin
        cap_addr <= addr;
        cap_data <= din;
      end
    end
  end

  assert_cap_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> ($past(we_n) && !$past(ce_n)));
endmodule

// File: rtl/fci_cmd_fsm.sv
module fci_cmd_fsm
  import fci_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int BLOCK_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_valid,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  input  logic          vpp_ok,
  input  logic          req_ready,
  input  logic          wsm_done,
  output logic          req_valid,
  output logic          req_kind,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          erase_hold,
  output rd_mode_e      rd_mode,
  output logic [7:0]    status
);
  localparam int HI_BITS = AW - BLOCK_BITS;

  seq_e seq_q;
  logic running_q, op_kind_q;
  logic err_e_q, err_w_q, vlow_q;
  logic active;

  assign active = req_valid | running_q;
  assign status = {(~active | erase_hold), erase_hold, err_e_q, err_w_q, vlow_q, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= SEQ_IDLE;
      rd_mode    <= RD_ARRAY;
      running_q  <= 1'b0;
      op_kind_q  <= REQ_ERASE;
      err_e_q    <= 1'b0;
      err_w_q    <= 1'b0;
      vlow_q     <= 1'b0;
      erase_hold <= 1'b0;
      req_valid  <= 1'b0;
      req_kind   <= REQ_ERASE;
      req_addr   <= '0;
      req_data   <= '0;
    end else begin
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        running_q <= 1'b1;
      end
      if (cap_valid) begin
        if (active && !erase_hold) begin
          if (cap_data == OPC_STATUS) rd_mode <= RD_STATUS;
          else if (cap_data == OPC_HOLD && running_q && op_kind_q == REQ_ERASE) begin
            erase_hold <= 1'b1;
            rd_mode    <= RD_STATUS;
          end
        end else if (erase_hold) begin
          case (cap_data)
            OPC_ARRAY:   rd_mode <= RD_ARRAY;
            OPC_IDENT:   rd_mode <= RD_IDENT;
            OPC_STATUS:  rd_mode <= RD_STATUS;
            OPC_CONFIRM: begin
              erase_hold <= 1'b0;
              rd_mode    <= RD_STATUS;
            end
            default: ;
          endcase
        end else begin
          case (seq_q)
            SEQ_ERASE: begin
              seq_q   <= SEQ_IDLE;
              rd_mode <= RD_STATUS;
              if (cap_data != OPC_CONFIRM) begin
                err_e_q <= 1'b1;
                err_w_q <= 1'b1;
              end else if (!vpp_ok) begin
                err_e_q <= 1'b1;
                vlow_q  <= 1'b1;
              end else begin
                req_valid <= 1'b1;
                req_kind  <= REQ_ERASE;
                op_kind_q <= REQ_ERASE;
                req_addr  <= {cap_addr[AW-1:BLOCK_BITS], {BLOCK_BITS{1'b0}}};
                req_data  <= '0;
              end
            end
            SEQ_WRITE: begin
              seq_q   <= SEQ_IDLE;
              rd_mode <= RD_STATUS;
              if (!vpp_ok) begin
                err_w_q <= 1'b1;
                vlow_q  <= 1'b1;
              end else begin
                req_valid <= 1'b1;
                req_kind  <= REQ_WRITE;
                op_kind_q <= REQ_WRITE;
                req_addr  <= cap_addr;
                req_data  <= cap_data;
              end
            end
            default: begin
              case (cap_data)
                OPC_ARRAY:   rd_mode <= RD_ARRAY;
                OPC_IDENT:   rd_mode <= RD_IDENT;
                OPC_STATUS:  rd_mode <= RD_STATUS;
                OPC_CLEAR: begin
                  err_e_q <= 1'b0;
                  err_w_q <= 1'b0;
                  vlow_q  <= 1'b0;
                end
                OPC_ERASE:   seq_q <= SEQ_ERASE;
                OPC_WRITE_A,
                OPC_WRITE_B: seq_q <= SEQ_WRITE;
                default: ;
              endcase
            end
          endcase
        end
      end
      if (wsm_done) begin
        running_q  <= 1'b0;
        erase_hold <= 1'b0;
      end
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_kind)));

  assert_launch_vpp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(vpp_ok));

  assert_erase_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == REQ_ERASE) |-> (req_addr[BLOCK_BITS-1:0] == '0 && HI_BITS > 0));

  assert_sticky_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_e_q) || $fell(err_w_q) || $fell(vlow_q)) |-> $past(cap_valid && cap_data == OPC_CLEAR));

  assert_hold_erase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_hold |-> (running_q && op_kind_q == REQ_ERASE));
endmodule

// File: rtl/fci_read_mux.sv
module fci_read_mux
  import fci_pkg::*;
#(
  parameter int AW = 20,
  parameter logic [7:0] MAKER_ID = 8'hA5,
  parameter logic [7:0] DEVICE_ID = 8'h6E
) (
  input  rd_mode_e      rd_mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    array_rdata,
  input  logic [7:0]    status,
  output logic [7:0]    host_rdata
);
  logic [7:0] ident_byte;

  always_comb begin
    if (addr == AW'(0))      ident_byte = MAKER_ID;
    else if (addr == AW'(1)) ident_byte = DEVICE_ID;
    else                     ident_byte = 8'h00;
  end

  always_comb begin
    case (rd_mode)
      RD_IDENT:  host_rdata = ident_byte;
      RD_STATUS: host_rdata = status;
      default:   host_rdata = array_rdata;
    endcase
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int BLOCK_BITS = 16,
  parameter logic [7:0] MAKER_ID = 8'hA5,
  parameter logic [7:0] DEVICE_ID = 8'h6E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          vpp_ok,
  input  logic [7:0]    array_rdata,
  output logic [7:0]    host_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_kind,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  input  logic          wsm_done,
  output logic          erase_hold
);
  logic          cap_valid;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  rd_mode_e      rd_mode;
  logic [7:0]    status;

  fci_bus_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  fci_cmd_fsm #(.AW(AW), .DW(DW), .BLOCK_BITS(BLOCK_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .cap_data(cap_data), .vpp_ok(vpp_ok), .req_ready(req_ready), .wsm_done(wsm_done),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .erase_hold(erase_hold), .rd_mode(rd_mode), .status(status)
  );

  fci_read_mux #(.AW(AW), .MAKER_ID(MAKER_ID), .DEVICE_ID(DEVICE_ID)) u_rdmux (
    .rd_mode(rd_mode), .addr(addr), .array_rdata(array_rdata), .status(status),
    .host_rdata(host_rdata)
  );
endmodule

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0]  din = '0;
  logic        vpp_ok = 1'b0;
  logic [7:0]  array_rdata = 8'hC3;
  logic [7:0]  host_rdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_kind;
  logic [19:0] req_addr;
  logic [7:0]  req_data;
  logic        wsm_done = 1'b0;
  logic        erase_hold;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [7:0] ARR = 8'hC3;
  localparam logic [7:0] MAKER = 8'hA5;
  localparam logic [7:0] DEV = 8'h6E;

  always #5 clk = ~clk;

  flash_cmd_if i_flash_cmd_if (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .vpp_ok(vpp_ok), .array_rdata(array_rdata), .host_rdata(host_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .wsm_done(wsm_done), .erase_hold(erase_hold)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [19:0] a, input logic [7:0] d, input bit sel = 1);
    @(negedge clk);
    addr = a; din = d; ce_n = !sel; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [19:0] a, input string tag, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, host_rdata, exp);
  endtask

  task automatic grant();
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk); wsm_done = 1'b1;
    @(negedge clk); wsm_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd(20'h0, "R2 reset array", ARR);
    check("R8 reset no request", req_valid, 0);
    check("R11 reset no hold", erase_hold, 0);

    // sweep of every opcode from idle, voltage low
    for (int x = 0; x < 256; x++) begin
      logic [7:0] expv;
      string tag;
      bus_wr(20'h0, 8'hFF);
      bus_wr(20'h0, x[7:0]);
      if (x == 8'hFF)      begin expv = ARR;   tag = "R2 sweep FF"; end
      else if (x == 8'h90) begin expv = MAKER; tag = "R3 sweep 90"; end
      else if (x == 8'h70) begin expv = 8'h80; tag = "R4 sweep 70"; end
      else                 begin expv = ARR;   tag = "R12 sweep undefined/setup keeps mode"; end
      rd(20'h0, tag, expv);
      if (x == 8'h20 || x == 8'h40 || x == 8'h10) bus_wr(20'h0, 8'h50);
      bus_wr(20'h0, 8'h50);
    end

    // R3 identifier addresses
    bus_wr(20'h0, 8'h90);
    rd(20'h0, "R3 maker", MAKER);
    rd(20'h1, "R3 device", DEV);
    rd(20'h2, "R3 other", 8'h00);
    // R1 strobe with chip enable high ignored
    bus_wr(20'h0, 8'h70, 0);
    rd(20'h0, "R1 ce high ignored", MAKER);

    // erase with voltage
    vpp_ok = 1'b1;
    bus_wr(20'h54321, 8'h20);
    bus_wr(20'h54321, 8'hD0);
    check("R6 erase valid", req_valid, 1);
    check("R6 erase kind", req_kind, 0);
    check("R6 erase block addr", req_addr, 20'h50000);
    rd(20'h0, "R12 R13 auto status busy", 8'h00);
    repeat (5) @(negedge clk);
    check("R8 held valid", req_valid, 1);
    check("R8 held addr", req_addr, 20'h50000);
    grant();
    #1 check("R8 dropped after ready", req_valid, 0);
    bus_wr(20'h0, 8'hFF);
    rd(20'h0, "R11 FF ignored busy", 8'h00);
    bus_wr(20'h0, 8'hB0);
    check("R11 hold out", erase_hold, 1);
    rd(20'h0, "R11 R13 held status", 8'hC0);
    bus_wr(20'h0, 8'hFF);
    rd(20'h0, "R11 array while held", ARR);
    bus_wr(20'h0, 8'hD0);
    check("R11 resume", erase_hold, 0);
    rd(20'h0, "R11 resumed status", 8'h00);
    finish_op();
    rd(20'h0, "R13 ready after done", 8'h80);

    // byte write with 10h
    bus_wr(20'h0ABCD, 8'h10);
    bus_wr(20'h0ABCD, 8'h5A);
    check("R7 write valid", req_valid, 1);
    check("R7 write kind", req_kind, 1);
    check("R7 write addr", req_addr, 20'h0ABCD);
    check("R7 write data", req_data, 8'h5A);
    grant();
    bus_wr(20'h0, 8'hB0);
    check("R11 B0 ignored on write", erase_hold, 0);
    rd(20'h0, "R11 write busy status", 8'h00);
    finish_op();
    // byte write with 40h
    bus_wr(20'hFFFFF, 8'h40);
    bus_wr(20'hFFFFF, 8'h00);
    check("R7 alt write addr", req_addr, 20'hFFFFF);
    check("R7 alt write data", req_data, 8'h00);
    check("R7 alt write kind", req_kind, 1);
    grant();
    finish_op();
    rd(20'h0, "R13 ready", 8'h80);

    // voltage low erase
    vpp_ok = 1'b0;
    bus_wr(20'h10000, 8'h20);
    bus_wr(20'h10000, 8'hD0);
    check("R9 no erase request", req_valid, 0);
    rd(20'h0, "R9 erase vlow status", 8'hA8);
    bus_wr(20'h0, 8'h70);
    rd(20'h0, "R5 sticky", 8'hA8);
    bus_wr(20'h0, 8'h33);
    rd(20'h0, "R12 undefined keeps status", 8'hA8);
    bus_wr(20'h0, 8'h50);
    rd(20'h0, "R5 cleared", 8'h80);
    // voltage low write
    bus_wr(20'h00010, 8'h40);
    bus_wr(20'h00010, 8'h77);
    check("R9 no write request", req_valid, 0);
    rd(20'h0, "R9 write vlow status", 8'h98);
    bus_wr(20'h0, 8'h50);
    // sequence error
    vpp_ok = 1'b1;
    bus_wr(20'h20000, 8'h20);
    bus_wr(20'h20000, 8'h33);
    check("R10 no request", req_valid, 0);
    rd(20'h0, "R10 sequence status", 8'hB0);
    bus_wr(20'h0, 8'h50);
    rd(20'h0, "R5 clear after sequence", 8'h80);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule